// File: doc/BRIEF.md
# Byte ALU with Carry-Linked Output Shifter

This block is the arithmetic core of a small microcoded byte processor. In one clock cycle it runs one of sixteen byte operations on an X and a Y operand. It can then move the byte one place left or right, with an extra link bit (L) entering at the vacated end. The byte that reaches the output produces the internal negative, zero, overflow and carry indications. A registered flags byte captures them when the microcode asks for it.

The link bit is a stored bit. Each cycle the microcode can keep it, clear it, set it, or load it from the adder carry. The value chosen in a cycle is the one that enters the shifted byte in that same cycle. A rotate through carry therefore takes a single microinstruction. The X operand can come from the operand bus or from a small unsigned constant field, which is widened with zeros.

Top module: `alu_shift_unit`

## Requirements
- R1: `aluOp` 0..7 selects, in order, X, Y, X+Y, X+Y+1, X AND Y, X OR Y, X XOR Y, NOT Y (all modulo 256).
- R2: `aluOp` 8..15 selects, in order, X+1, Y+1, X AND 1, Y AND 1, Y+(NOT X)+1, NOT X, 8'hFF, 8'h00.
- R3: When `useConst` is 1, the X operand is `{3'b000, constIn}` and `xIn` has no effect on the output. When `useConst` is 0, the X operand is `xIn`.
- R4: `lCtrl` sets the link value used in the cycle and stored at the clock edge, visible on `lBit`: 0 keeps the stored value, 1 gives 0, 2 gives 1, 3 gives the adder carry.
- R5: `shiftCtrl` 0 passes the byte unchanged, 1 moves it right one place, 2 moves it left one place, and 3 behaves as 0.
- R6: On a left move, `result` is {byte[6:0], link} and `cFlag` is byte bit 7. On a right move, `result` is {link, byte[7:1]} and `cFlag` is byte bit 0. Here link is the R4 value for the same cycle.
- R7: `nFlag` is `result` bit 7, and `zFlag` is 1 exactly when `result` is 0.
- R8: For the adder operations (codes 2, 3, 8, 9, 12), `vFlag` is the two's-complement overflow of the addition, whatever the shift. With no shift, `cFlag` is the carry out of bit 7.
- R9: For all other codes, `vFlag` is 0. With no shift, `cFlag` is 0.
- R10: At a clock edge with `loadFlags` = 1, `flagsReg` becomes {4'b0000, N, Z, V, C}, with C in bit 0 and N in bit 3. With `loadFlags` = 0, `flagsReg` holds its value.
- R11: While `rstN` is low, `lBit` and `flagsReg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xIn | input | 8 | X operand from the bus |
| constIn | input | 5 | Unsigned constant field |
| useConst | input | 1 | Take X from the constant field |
| yIn | input | 8 | Y operand |
| aluOp | input | 4 | Operation code |
| lCtrl | input | 2 | Link bit control |
| shiftCtrl | input | 2 | Shift control |
| loadFlags | input | 1 | Capture flags at the clock edge |
| result | output | 8 | Shifted result |
| nFlag | output | 1 | Internal negative flag |
| zFlag | output | 1 | Internal zero flag |
| vFlag | output | 1 | Internal overflow flag |
| cFlag | output | 1 | Internal carry flag |
| flagsReg | output | 8 | Registered flags byte |
| lBit | output | 1 | Stored link bit |

## Verification
The properties assume that the control inputs carry known values at every rising clock edge. They also assume that those inputs stay steady across the edge, since the flag and link checks compare the value registered at the edge with the combinational value just before it. The stimulus changes every input only at the falling edge and never leaves an input undriven after reset. It covers every operation code, all four link and shift settings including the unused shift code, and a random mix of the load-flags strobe.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  // Output byte source chosen by the control decode
  typedef enum logic [2:0] {
    RS_SUM  = 3'd0,
    RS_AND  = 3'd1,
    RS_OR   = 3'd2,
    RS_XOR  = 3'd3,
    RS_NOTY = 3'd4,
    RS_NOTX = 3'd5,
    RS_ONES = 3'd6,
    RS_ZERO = 3'd7
  } resSelE;

  // Second adder operand
  typedef enum logic [1:0] {
    B_ZERO = 2'd0,
    B_Y    = 2'd1,
    B_NOTX = 2'd2
  } bSelE;

  // Strobes from control to datapath
  typedef struct packed {
    logic       aIsY;
    bSelE       bSel;
    logic       cin;
    logic       arith;
    logic       andLhsY;
    logic       andRhsOne;
    resSelE     resSel;
    logic [1:0] lMode;
    logic       shl;
    logic       shr;
    logic       ldFlags;
  } aluStrobesT;

endpackage

// File: rtl/alu_shift_ctrl.sv
module alu_shift_ctrl
  import alu_shift_pkg::*;
(
  input  logic [3:0] aluOp,
  input  logic [1:0] lCtrl,
  input  logic [1:0] shiftCtrl,
  input  logic       loadFlags,
  output aluStrobesT strobes
);

  always_comb begin
    strobes           = '0;
    strobes.bSel      = B_ZERO;
    strobes.resSel    = RS_SUM;
    strobes.lMode     = lCtrl;
    strobes.shr       = (shiftCtrl == 2'b01);
    strobes.shl       = (shiftCtrl == 2'b10);
    strobes.ldFlags   = loadFlags;
    unique case (aluOp)
      4'd0:  ;                                             // pass X via adder
      4'd1:  strobes.aIsY = 1'b1;                          // pass Y via adder
      4'd2:  begin strobes.bSel = B_Y; strobes.arith = 1'b1; end
      4'd3:  begin strobes.bSel = B_Y; strobes.cin = 1'b1; strobes.arith = 1'b1; end
      4'd4:  strobes.resSel = RS_AND;
      4'd5:  strobes.resSel = RS_OR;
      4'd6:  strobes.resSel = RS_XOR;
      4'd7:  strobes.resSel = RS_NOTY;
      4'd8:  begin strobes.cin = 1'b1; strobes.arith = 1'b1; end
      4'd9:  begin strobes.aIsY = 1'b1; strobes.cin = 1'b1; strobes.arith = 1'b1; end
      4'd10: begin strobes.resSel = RS_AND; strobes.andRhsOne = 1'b1; end
      4'd11: begin strobes.resSel = RS_AND; strobes.andLhsY = 1'b1; strobes.andRhsOne = 1'b1; end
      4'd12: begin
        strobes.aIsY  = 1'b1;
        strobes.bSel  = B_NOTX;
        strobes.cin   = 1'b1;
        strobes.arith = 1'b1;
      end
      4'd13: strobes.resSel = RS_NOTX;
      4'd14: strobes.resSel = RS_ONES;
      default: strobes.resSel = RS_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_shift_datapath.sv
module alu_shift_datapath
  import alu_shift_pkg::*;
#(
  parameter int W       = 8,
  parameter int CONST_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [W-1:0]       xIn,
  input  logic [CONST_W-1:0] constIn,
  input  logic               useConst,
  input  logic [W-1:0]       yIn,
  input  aluStrobesT         strobes,
  output logic [W-1:0]       result,
  output logic               nFlag,
  output logic               zFlag,
  output logic               vFlag,
  output logic               cFlag,
  output logic [W-1:0]       flagsReg,
  output logic               lBit
);

  localparam int PAD_W = W - CONST_W;
  localparam int HI_W  = W - 4;

  logic [W-1:0] xOp, aOp, bOp, andL, andR, aluRes, shifted;
  logic [W:0]   sumFull;
  logic         addV, aluC, aluV, lNext, cOut, lReg;

  assign xOp = useConst ? {{PAD_W{1'b0}}, constIn} : xIn;

  // Single adder shared by all add and pass operations
  always_comb begin
    aOp = strobes.aIsY ? yIn : xOp;
    unique case (strobes.bSel)
      B_Y:     bOp = yIn;
      B_NOTX:  bOp = ~xOp;
      default: bOp = '0;
    endcase
  end

  assign sumFull = {1'b0, aOp} + {1'b0, bOp} + {{W{1'b0}}, strobes.cin};
  assign addV    = (aOp[W-1] == bOp[W-1]) && (sumFull[W-1] != aOp[W-1]);
  assign andL    = strobes.andLhsY ? yIn : xOp;
  assign andR    = strobes.andRhsOne ? {{(W-1){1'b0}}, 1'b1} : yIn;

  always_comb begin
    unique case (strobes.resSel)
      RS_SUM:  aluRes = sumFull[W-1:0];
      RS_AND:  aluRes = andL & andR;
      RS_OR:   aluRes = xOp | yIn;
      RS_XOR:  aluRes = xOp ^ yIn;
      RS_NOTY: aluRes = ~yIn;
      RS_NOTX: aluRes = ~xOp;
      RS_ONES: aluRes = '1;
      default: aluRes = '0;
    endcase
  end

  assign aluC = strobes.arith & sumFull[W];
  assign aluV = strobes.arith & addV;

  // Link value for this cycle
  always_comb begin
    unique case (strobes.lMode)
      2'd0:    lNext = lReg;
      2'd1:    lNext = 1'b0;
      2'd2:    lNext = 1'b1;
      default: lNext = aluC;
    endcase
  end

  // Output shifter
  always_comb begin
    if (strobes.shl) begin
      shifted = {aluRes[W-2:0], lNext};
      cOut    = aluRes[W-1];
    end else if (strobes.shr) begin
      shifted = {lNext, aluRes[W-1:1]};
      cOut    = aluRes[0];
    end else begin
      shifted = aluRes;
      cOut    = aluC;
    end
  end

  assign result = shifted;
  assign nFlag  = shifted[W-1];
  assign zFlag  = ~|shifted;
  assign vFlag  = aluV;
  assign cFlag  = cOut;
  assign lBit   = lReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lReg     <= 1'b0;
      flagsReg <= '0;
    end else begin
      lReg <= lNext;
      if (strobes.ldFlags) flagsReg <= {{HI_W{1'b0}}, nFlag, zFlag, vFlag, cFlag};
    end
  end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_shift_pkg::*;
#(
  parameter int W       = 8,
  parameter int CONST_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [W-1:0]       xIn,
  input  logic [CONST_W-1:0] constIn,
  input  logic               useConst,
  input  logic [W-1:0]       yIn,
  input  logic [3:0]         aluOp,
  input  logic [1:0]         lCtrl,
  input  logic [1:0]         shiftCtrl,
  input  logic               loadFlags,
  output logic [W-1:0]       result,
  output logic               nFlag,
  output logic               zFlag,
  output logic               vFlag,
  output logic               cFlag,
  output logic [W-1:0]       flagsReg,
  output logic               lBit
);

  aluStrobesT strobes;

  alu_shift_ctrl u_ctrl (
    .aluOp(aluOp), .lCtrl(lCtrl), .shiftCtrl(shiftCtrl),
    .loadFlags(loadFlags), .strobes(strobes)
  );

  alu_shift_datapath #(.W(W), .CONST_W(CONST_W)) u_dp (
    .clk(clk), .rstN(rstN), .xIn(xIn), .constIn(constIn), .useConst(useConst),
    .yIn(yIn), .strobes(strobes), .result(result), .nFlag(nFlag), .zFlag(zFlag),
    .vFlag(vFlag), .cFlag(cFlag), .flagsReg(flagsReg), .lBit(lBit)
  );

endmodule

// File: rtl/alu_shift_chk.sv
module alu_shift_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [3:0]   aluOp,
  input logic [1:0]   lCtrl,
  input logic [1:0]   shiftCtrl,
  input logic         loadFlags,
  input logic [W-1:0] result,
  input logic         nFlag,
  input logic         zFlag,
  input logic         vFlag,
  input logic         cFlag,
  input logic [W-1:0] flagsReg,
  input logic         lBit
);

  logic isAdd, noShift;
  assign isAdd   = (aluOp == 4'd2) || (aluOp == 4'd3) || (aluOp == 4'd8) ||
                   (aluOp == 4'd9) || (aluOp == 4'd12);
  assign noShift = (shiftCtrl == 2'b00) || (shiftCtrl == 2'b11);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadFlags |=> $stable(flagsReg));

  // R10
  flag_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadFlags |=> (flagsReg[3:0] == {$past(nFlag), $past(zFlag), $past(vFlag), $past(cFlag)})
                  && (flagsReg[W-1:4] == '0));

  // R4
  l_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lCtrl == 2'd1) |=> !lBit);

  // R4
  l_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lCtrl == 2'd2) |=> lBit);

  // R4
  l_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lCtrl == 2'd0) |=> $stable(lBit));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    zFlag == (result == '0));

  // R9
  logic_vc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!isAdd && noShift) |-> (!vFlag && !cFlag));

  // R6
  shl_insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftCtrl == 2'b10 && lCtrl == 2'd2) |-> result[0]);

  // R6
  shr_insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftCtrl == 2'b01 && lCtrl == 2'd1) |-> !result[W-1]);

  // R11
  always @(posedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (!lBit && flagsReg == '0);
    end
  end

endmodule

bind alu_shift_unit alu_shift_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .aluOp(aluOp), .lCtrl(lCtrl), .shiftCtrl(shiftCtrl),
  .loadFlags(loadFlags), .result(result), .nFlag(nFlag), .zFlag(zFlag),
  .vFlag(vFlag), .cFlag(cFlag), .flagsReg(flagsReg), .lBit(lBit)
);

// File: tb/sim_alu_shift_unit.sv
`timescale 1ns/1ps
module sim_alu_shift_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] xIn = '0, yIn = '0;
  logic [4:0] constIn = '0;
  logic       useConst = 1'b0;
  logic [3:0] aluOp = '0;
  logic [1:0] lCtrl = '0, shiftCtrl = '0;
  logic       loadFlags = 1'b0;
  logic [7:0] result, flagsReg;
  logic       nFlag, zFlag, vFlag, cFlag, lBit;

  int checks = 0;
  int fails  = 0;

  // reference state
  int mL = 0;
  int mFlags = 0;
  // expected combinational values
  int eRes, eN, eZ, eV, eC, eLnext;

  always #5 clk = ~clk;

  alu_shift_unit u0 (
    .clk(clk), .rstN(rstN), .xIn(xIn), .constIn(constIn), .useConst(useConst),
    .yIn(yIn), .aluOp(aluOp), .lCtrl(lCtrl), .shiftCtrl(shiftCtrl),
    .loadFlags(loadFlags), .result(result), .nFlag(nFlag), .zFlag(zFlag),
    .vFlag(vFlag), .cFlag(cFlag), .flagsReg(flagsReg), .lBit(lBit)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (op=%0d l=%0d sh=%0d x=%0h y=%0h)",
               req, what, act, exp, aluOp, lCtrl, shiftCtrl, xIn, yIn);
    end
  endtask

  task automatic computeModel();
    int x, y, a, b, cin, sum, r, addC, addV, isAdd, bit7;
    x = useConst ? int'(constIn) : int'(xIn);
    y = int'(yIn);
    isAdd = 0; a = 0; b = 0; cin = 0; r = 0;
    case (int'(aluOp))
      0:  r = x;
      1:  r = y;
      2:  begin a = x; b = y; isAdd = 1; end
      3:  begin a = x; b = y; cin = 1; isAdd = 1; end
      4:  r = x & y;
      5:  r = x | y;
      6:  r = x ^ y;
      7:  r = 255 - y;
      8:  begin a = x; cin = 1; isAdd = 1; end
      9:  begin a = y; cin = 1; isAdd = 1; end
      10: r = x % 2;
      11: r = y % 2;
      12: begin a = y; b = 255 - x; cin = 1; isAdd = 1; end
      13: r = 255 - x;
      14: r = 255;
      default: r = 0;
    endcase
    addC = 0; addV = 0;
    if (isAdd != 0) begin
      sum  = a + b + cin;
      r    = sum % 256;
      addC = sum / 256;
      addV = ((a >= 128) == (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0;
    end
    case (int'(lCtrl))
      0: eLnext = mL;
      1: eLnext = 0;
      2: eLnext = 1;
      default: eLnext = addC;
    endcase
    if (shiftCtrl == 2'b10) begin
      bit7 = r / 128;
      eRes = (r * 2) % 256 + eLnext;
      eC   = bit7;
    end else if (shiftCtrl == 2'b01) begin
      eC   = r % 2;
      eRes = r / 2 + eLnext * 128;
    end else begin
      eRes = r;
      eC   = addC;
    end
    eV = addV;
    eN = eRes / 128;
    eZ = (eRes == 0) ? 1 : 0;
  endtask

  // Drive one cycle, check combinational outputs, then registered state
  task automatic step(input logic [7:0] xv, input logic [7:0] yv, input logic [4:0] cv,
                      input logic uc, input logic [3:0] op, input logic [1:0] lc,
                      input logic [1:0] sc, input logic lf, input string tag);
    string rTag, cTag;
    @(negedge clk);
    xIn = xv; yIn = yv; constIn = cv; useConst = uc;
    aluOp = op; lCtrl = lc; shiftCtrl = sc; loadFlags = lf;
    #2;
    computeModel();
    if (tag != "") rTag = tag;
    else if (sc == 2'b01 || sc == 2'b10) rTag = "R6";
    else if (sc == 2'b11) rTag = "R5";
    else rTag = (op < 4'd8) ? "R1" : "R2";
    cTag = (sc == 2'b01 || sc == 2'b10) ? "R6" :
           ((op == 2 || op == 3 || op == 8 || op == 9 || op == 12) ? "R8" : "R9");
    check(rTag, "result", int'(result), eRes);
    check("R7", "nFlag", int'(nFlag), eN);
    check("R7", "zFlag", int'(zFlag), eZ);
    check(cTag == "R6" ? "R8" : cTag, "vFlag", int'(vFlag), eV);
    check(cTag, "cFlag", int'(cFlag), eC);
    @(posedge clk);
    mL = eLnext;
    if (lf) mFlags = eN * 8 + eZ * 4 + eV * 2 + eC;
    #1;
    check("R4", "lBit", int'(lBit), mL);
    check("R10", "flagsReg", int'(flagsReg), mFlags);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R11", "lBit in reset", int'(lBit), 0);
    check("R11", "flagsReg in reset", int'(flagsReg), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 / R2: every code, plain operands
    for (int op = 0; op < 16; op++)
      step(8'h5A, 8'hC3, 5'd0, 1'b0, 4'(op), 2'd0, 2'd0, 1'b1, "");
    // R8: signed overflow on X+Y and X+1
    step(8'h7F, 8'h01, 5'd0, 1'b0, 4'd2, 2'd0, 2'd0, 1'b1, "R8");
    step(8'h7F, 8'h00, 5'd0, 1'b0, 4'd8, 2'd0, 2'd0, 1'b1, "R8");
    // R8: carry out and zero on Y+~X+1 with equal operands
    step(8'h05, 8'h05, 5'd0, 1'b0, 4'd12, 2'd0, 2'd0, 1'b1, "R8");
    step(8'h06, 8'h05, 5'd0, 1'b0, 4'd12, 2'd0, 2'd0, 1'b1, "R8");
    step(8'hFF, 8'hFF, 5'd0, 1'b0, 4'd9, 2'd0, 2'd0, 1'b1, "R8");
    // R3: constant replaces X, bus X ignored
    step(8'hFF, 8'h00, 5'd31, 1'b1, 4'd0, 2'd0, 2'd0, 1'b0, "R3");
    step(8'hAA, 8'h10, 5'd17, 1'b1, 4'd2, 2'd0, 2'd0, 1'b0, "R3");
    step(8'h00, 8'h00, 5'd1, 1'b1, 4'd13, 2'd0, 2'd0, 1'b0, "R3");
    // R4: link settings
    step(8'h00, 8'h00, 5'd0, 1'b0, 4'd15, 2'd2, 2'd0, 1'b0, "");
    step(8'h00, 8'h00, 5'd0, 1'b0, 4'd15, 2'd0, 2'd0, 1'b0, "");
    step(8'h00, 8'h00, 5'd0, 1'b0, 4'd15, 2'd1, 2'd0, 1'b0, "");
    step(8'hFF, 8'h01, 5'd0, 1'b0, 4'd2, 2'd3, 2'd0, 1'b0, "");
    // R6: rotate-left through link taken from set
    step(8'h00, 8'h81, 5'd0, 1'b0, 4'd1, 2'd2, 2'd2, 1'b1, "R6");
    step(8'h00, 8'h81, 5'd0, 1'b0, 4'd1, 2'd1, 2'd1, 1'b1, "R6");
    step(8'h00, 8'h01, 5'd0, 1'b0, 4'd1, 2'd2, 2'd1, 1'b1, "R6");
    // R5: unused shift code acts as pass
    step(8'h00, 8'h81, 5'd0, 1'b0, 4'd1, 2'd2, 2'd3, 1'b1, "R5");
    // R10: flags hold when not loading
    step(8'h00, 8'h00, 5'd0, 1'b0, 4'd15, 2'd0, 2'd0, 1'b1, "");
    step(8'h80, 8'h00, 5'd0, 1'b0, 4'd0, 2'd0, 2'd0, 1'b0, "");

    // random mix
    for (int i = 0; i < 3000; i++)
      step(8'($urandom), 8'($urandom), 5'($urandom), 1'($urandom), 4'($urandom),
           2'($urandom), 2'($urandom), 1'($urandom), "");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule